// File: doc/BRIEF.md
# Statically Scheduled Dataflow Processing Element

This block is one word-level processing element for a reconfigurable compute array. It runs a fixed sequence of instructions from a small instruction store. The store behaves as a circular schedule: a slot counter steps through the words in lock-step with every other element of the array and wraps back to slot 0 at a programmable schedule length. There is no branching and no register file. The only state in the datapath is an accumulator and a one-bit predicate flag.

Each instruction takes its first operand from the accumulator, or from zero when the accumulator is not selected. It takes its second operand from one of four neighbour result ports. The element writes the result back to its accumulator. The accumulator drives a single result port that every neighbour sees, so any of them can use the value as an operand in the following cycle.

Conditional work is expressed by predicating instructions on the flag, which a compare instruction sets. Multiply-accumulate work is not done here. The element hands its operands to an external arithmetic unit through a request port and goes on to the next slot without waiting.

Top module: `sspe_core`

## Requirements
- R1: After reset `slot_idx` is 0, `result_out` is 0, `mac_req_valid` is 0 and the predicate flag is 0. Every instruction-store entry reads as the no-operation word (all zero), so running an unloaded schedule leaves `result_out` at 0.
- R2: Instruction word fields: bits [8:5] opcode, [4:3] neighbour select, [2] use-accumulator, [1] predicate-enable, [0] predicate-sense. Operand A is the accumulator when bit 2 is 1 and zero otherwise. Operand B is `nbr_data[select]`. The opcodes that write the accumulator are 1 add (A+B), 2 subtract (A-B), 3 AND, 4 OR, 5 XOR and 6 move (B). The new value appears on `result_out` one clock edge after the step that executes the instruction.
- R3: On each clock edge with `step_en`=1 and `slot_restart`=0, the element executes the word at `slot_idx` and `slot_idx` advances by one. It wraps to 0 when `slot_idx`+1 >= `sched_len` or when it reaches depth-1, so a length of 0 behaves as 1 and a length above the depth behaves as the depth.
- R4: On an edge with `step_en`=0 and `slot_restart`=0, `slot_idx`, `result_out` and the predicate flag hold their values, and `mac_req_valid` is 0 on the next cycle.
- R5: On an edge with `slot_restart`=1, `slot_idx` becomes 0 and no instruction executes. The accumulator keeps its value and `mac_req_valid` is 0 on the next cycle.
- R6: Opcode 7 (compare) sets the predicate flag to 1 when A < B (unsigned) and to 0 otherwise. It leaves the accumulator unchanged.
- R7: An instruction with predicate-enable 1 executes only when the predicate flag equals its predicate-sense bit. Otherwise it acts as a no-operation: the accumulator and the flag are unchanged and no multiply request is raised.
- R8: Opcode 8 (multiply issue) raises `mac_req_valid` for exactly the cycle after the step, with `mac_req_a` = A and `mac_req_b` = B. It leaves the accumulator unchanged, and the schedule keeps advancing on the following steps.
- R9: Opcode 0 and the unused opcodes 9 to 15 change neither the accumulator nor the flag.
- R10: A write through the load port (`load_en`=1) stores `load_word` at `load_addr` on the clock edge. This may happen while the schedule runs. An instruction executing on the same edge uses the old word, and later fetches of that slot use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Instruction-store write strobe |
| load_addr | input | 5 | Instruction-store write address |
| load_word | input | 9 | Instruction word to store |
| step_en | input | 1 | Global step: execute the current slot and advance |
| slot_restart | input | 1 | Global restart: return to slot 0 without executing |
| sched_len | input | 6 | Schedule length in slots |
| nbr_data | input | 4x32 | Result words from the four neighbours |
| result_out | output | 32 | Accumulator, broadcast to all neighbours |
| slot_idx | output | 5 | Current schedule slot |
| mac_req_valid | output | 1 | Multiply-accumulate request strobe |
| mac_req_a | output | 32 | Multiply-accumulate first operand |
| mac_req_b | output | 32 | Multiply-accumulate second operand |

## Verification
Each result is due exactly one clock edge after the step that causes it. Accumulator writes, predicate updates, slot advance, wrap, restart and the multiply request all sit one register away from the inputs. A predicated instruction sees the flag written by the step before it. The bench drives inputs just after a falling edge and works out the expected state for the coming rising edge from its own arithmetic model. It compares `result_out`, `slot_idx` and the request port at the next falling edge, so every check lands in the cycle its result is due. Directed programs cover each opcode, both predicate senses, stalls, restarts, several schedule lengths and loads into the running slot. A long run of pseudo-random programs and inputs covers the rest.

// File: rtl/sspe_pkg.sv
// Package: shared opcode encoding for the statically scheduled processing element.
// Assumes a 4-bit opcode field at the top of every instruction word.
package sspe_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_MOVE = 4'd6,
        OP_CMP  = 4'd7,
        OP_MAC  = 4'd8
    } sspe_op_e;

endpackage

// File: rtl/sspe_imem.sv
// Module: circular instruction store. One synchronous write port, one
// combinational read port addressed by the slot counter.
// Assumes: a write and a read of the same entry in one cycle return the old word.
module sspe_imem #(
    parameter int DEPTH = 32,
    parameter int IW    = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [IW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [IW-1:0] rd_data
);

    logic [IW-1:0] mem [DEPTH];

    // Clear every entry to the no-operation word on reset; otherwise take loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Fetch the word for the current slot.
    always_comb begin
        rd_data = mem[rd_addr];
    end

endmodule

// File: rtl/sspe_seq.sv
// Module: lock-step slot sequencer. Advances one slot per global step and
// wraps at the programmed schedule length or at the store depth.
// Assumes: restart takes priority over step; a length of 0 acts as 1.
module sspe_seq #(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic          restart,
    input  logic [AW:0]   sched_len,
    output logic [AW-1:0] slot,
    output logic          fire
);

    logic          at_end;
    logic [AW:0]   slot_plus;

    // Decide whether the current slot is the last of the schedule.
    always_comb begin
        slot_plus = {1'b0, slot} + (AW+1)'(1);
        at_end    = (slot_plus >= sched_len) || (slot == AW'(DEPTH-1));
        fire      = step_en && !restart;
    end

    // Slot counter: restart to 0, else advance or wrap on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (restart) begin
            slot <= '0;
        end else if (step_en) begin
            slot <= at_end ? '0 : slot_plus[AW-1:0];
        end
    end

endmodule

// File: rtl/sspe_alu.sv
// Module: combinational word ALU. Computes the accumulator candidate and
// tells the core which piece of state the opcode targets.
// Assumes: operand A is already zeroed by the core when the accumulator is not used.
module sspe_alu
    import sspe_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [DW-1:0]    op_a,
    input  logic [DW-1:0]    op_b,
    output logic [DW-1:0]    res,
    output logic             wr_acc,
    output logic             wr_pred,
    output logic             pred_val,
    output logic             mac_issue
);

    sspe_op_e op;

    // Decode the opcode and form the result and the write controls.
    always_comb begin
        op        = sspe_op_e'(opc);
        res       = op_b;
        wr_acc    = 1'b0;
        wr_pred   = 1'b0;
        pred_val  = op_a < op_b;
        mac_issue = 1'b0;
        case (op)
            OP_ADD:  begin res = op_a + op_b; wr_acc = 1'b1; end
            OP_SUB:  begin res = op_a - op_b; wr_acc = 1'b1; end
            OP_AND:  begin res = op_a & op_b; wr_acc = 1'b1; end
            OP_OR:   begin res = op_a | op_b; wr_acc = 1'b1; end
            OP_XOR:  begin res = op_a ^ op_b; wr_acc = 1'b1; end
            OP_MOVE: begin res = op_b;        wr_acc = 1'b1; end
            OP_CMP:  begin wr_pred = 1'b1; end
            OP_MAC:  begin mac_issue = 1'b1; end
            default: begin end
        endcase
    end

endmodule

// File: rtl/sspe_core.sv
// Module: top of the statically scheduled processing element. Fetches the
// word for the current slot, selects operands from the accumulator and one
// neighbour port, applies predication, and updates the accumulator, the
// predicate flag and the multiply request register.
// Assumes: all elements of the array see the same step and restart inputs,
// so they stay in lock-step; NBR is a power of two.
module sspe_core
    import sspe_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    parameter int NBR   = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int SEL_W = $clog2(NBR),
    localparam int IW    = OPC_W + SEL_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic [AW-1:0]           load_addr,
    input  logic [IW-1:0]           load_word,
    input  logic                    step_en,
    input  logic                    slot_restart,
    input  logic [AW:0]             sched_len,
    input  logic [NBR-1:0][DW-1:0]  nbr_data,
    output logic [DW-1:0]           result_out,
    output logic [AW-1:0]           slot_idx,
    output logic                    mac_req_valid,
    output logic [DW-1:0]           mac_req_a,
    output logic [DW-1:0]           mac_req_b
);

    logic [IW-1:0]    instr;
    logic             fire;
    logic [OPC_W-1:0] f_opc;
    logic [SEL_W-1:0] f_sel;
    logic             f_use_acc;
    logic             f_pred_en;
    logic             f_pred_sense;
    logic [DW-1:0]    acc_q;
    logic             pred_q;
    logic [DW-1:0]    op_a;
    logic [DW-1:0]    op_b;
    logic [DW-1:0]    alu_res;
    logic             alu_wr_acc;
    logic             alu_wr_pred;
    logic             alu_pred_val;
    logic             alu_mac;
    logic             enabled;
    logic             commit;

    sspe_imem #(.DEPTH(DEPTH), .IW(IW)) u_imem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (load_en),
        .wr_addr (load_addr),
        .wr_data (load_word),
        .rd_addr (slot_idx),
        .rd_data (instr)
    );

    sspe_seq #(.DEPTH(DEPTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .restart   (slot_restart),
        .sched_len (sched_len),
        .slot      (slot_idx),
        .fire      (fire)
    );

    // Split the fetched word into its fields.
    always_comb begin
        f_opc        = instr[IW-1 -: OPC_W];
        f_sel        = instr[3 +: SEL_W];
        f_use_acc    = instr[2];
        f_pred_en    = instr[1];
        f_pred_sense = instr[0];
    end

    // Operand selection: accumulator or zero, and one neighbour port.
    always_comb begin
        op_a = f_use_acc ? acc_q : '0;
        op_b = nbr_data[f_sel];
    end

    sspe_alu #(.DW(DW)) u_alu (
        .opc       (f_opc),
        .op_a      (op_a),
        .op_b      (op_b),
        .res       (alu_res),
        .wr_acc    (alu_wr_acc),
        .wr_pred   (alu_wr_pred),
        .pred_val  (alu_pred_val),
        .mac_issue (alu_mac)
    );

    // Predication gate: an enabled instruction only commits on a step.
    always_comb begin
        enabled = !f_pred_en || (pred_q == f_pred_sense);
        commit  = fire && enabled;
    end

    // Accumulator: written by committed arithmetic, logic and move opcodes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (commit && alu_wr_acc) begin
            acc_q <= alu_res;
        end
    end

    // Predicate flag: written by committed compare opcodes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= 1'b0;
        end else if (commit && alu_wr_pred) begin
            pred_q <= alu_pred_val;
        end
    end

    // Multiply request: a one-cycle strobe with its operands captured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mac_req_valid <= 1'b0;
            mac_req_a     <= '0;
            mac_req_b     <= '0;
        end else begin
            mac_req_valid <= commit && alu_mac;
            if (commit && alu_mac) begin
                mac_req_a <= op_a;
                mac_req_b <= op_b;
            end
        end
    end

    // Broadcast the accumulator to every neighbour.
    always_comb begin
        result_out = acc_q;
    end

endmodule

// File: rtl/sspe_chk.sv
// Module: property checker for sspe_core, attached by bind below.
// Assumes: it observes only the top-level ports.
module sspe_chk #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    parameter int NBR   = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   step_en,
    input logic                   slot_restart,
    input logic [AW:0]            sched_len,
    input logic [DW-1:0]          result_out,
    input logic [AW-1:0]          slot_idx,
    input logic                   mac_req_valid
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (slot_idx == '0) && (result_out == '0) && !mac_req_valid);

    // R5
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_restart |=> (slot_idx == '0) && $stable(result_out) && !mac_req_valid);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !slot_restart) |=> $stable(slot_idx) && $stable(result_out) && !mac_req_valid);

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !slot_restart &&
         (({1'b0, slot_idx} + (AW+1)'(1) >= sched_len) || (slot_idx == AW'(DEPTH-1))))
        |=> (slot_idx == '0));

    // R3
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !slot_restart &&
         ({1'b0, slot_idx} + (AW+1)'(1) < sched_len) && (slot_idx != AW'(DEPTH-1)))
        |=> (slot_idx == $past(slot_idx) + AW'(1)));

    // R8
    mac_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mac_req_valid |-> $stable(result_out));

endmodule

bind sspe_core sspe_chk #(.DW(DW), .DEPTH(DEPTH), .NBR(NBR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_en       (step_en),
    .slot_restart  (slot_restart),
    .sched_len     (sched_len),
    .result_out    (result_out),
    .slot_idx      (slot_idx),
    .mac_req_valid (mac_req_valid)
);

// File: tb/sim_sspe_core.sv
// Bench: drives sspe_core with directed programs and pseudo-random runs,
// predicting every output from an arithmetic model of the requirements.
module sim_sspe_core;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                load_en = 1'b0;
    logic [4:0]          load_addr = '0;
    logic [8:0]          load_word = '0;
    logic                step_en = 1'b0;
    logic                slot_restart = 1'b0;
    logic [5:0]          sched_len = 6'd32;
    logic [3:0][31:0]    nbr_data = '0;
    logic [31:0]         result_out;
    logic [4:0]          slot_idx;
    logic                mac_req_valid;
    logic [31:0]         mac_req_a;
    logic [31:0]         mac_req_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string force_tag = "";

    logic [8:0]  m_imem [32];
    logic [4:0]  m_slot;
    logic [31:0] m_acc;
    logic        m_pred;
    logic [31:0] rng = 32'h1234_5678;

    sspe_core u0 (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_word(load_word), .step_en(step_en), .slot_restart(slot_restart),
        .sched_len(sched_len), .nbr_data(nbr_data), .result_out(result_out),
        .slot_idx(slot_idx), .mac_req_valid(mac_req_valid),
        .mac_req_a(mac_req_a), .mac_req_b(mac_req_b)
    );

    always #2 clk = ~clk;

    function automatic logic [8:0] enc(input int op, input int sel, input bit ua, input bit pe, input bit ps);
        return {4'(op), 2'(sel), ua, pe, ps};
    endfunction

    task automatic next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // One clock: predict from the applied inputs, clock, then compare.
    task automatic tick();
        logic [8:0]  w;
        logic [3:0]  op;
        logic [31:0] a, b;
        logic [4:0]  n_slot;
        logic [31:0] n_acc, n_ma, n_mb;
        logic        n_pred, n_mv, ok;
        int          len;
        string       tg, tg_s;
        n_slot = m_slot; n_acc = m_acc; n_pred = m_pred;
        n_mv = 1'b0; n_ma = '0; n_mb = '0;
        if (slot_restart) begin
            n_slot = '0; tg = "R5"; tg_s = "R5";
        end else if (step_en) begin
            w  = m_imem[m_slot];
            op = w[8:5];
            a  = w[2] ? m_acc : 32'h0;
            b  = nbr_data[w[4:3]];
            ok = !w[1] || (m_pred == w[0]);
            if (w[1]) tg = "R7";
            else if (op == 4'd7) tg = "R6";
            else if (op == 4'd8) tg = "R8";
            else if (op == 4'd0 || op > 4'd8) tg = "R9";
            else tg = "R2";
            if (ok) begin
                case (op)
                    4'd1: n_acc = a + b;
                    4'd2: n_acc = a - b;
                    4'd3: n_acc = a & b;
                    4'd4: n_acc = a | b;
                    4'd5: n_acc = a ^ b;
                    4'd6: n_acc = b;
                    4'd7: n_pred = (a < b);
                    4'd8: begin n_mv = 1'b1; n_ma = a; n_mb = b; end
                    default: ;
                endcase
            end
            len = (sched_len == 0) ? 1 : (sched_len > 32) ? 32 : int'(sched_len);
            n_slot = (int'(m_slot) + 1 >= len) ? 5'd0 : m_slot + 5'd1;
            tg_s = "R3";
        end else begin
            tg = "R4"; tg_s = "R4";
        end
        if (force_tag != "") tg = force_tag;
        if (load_en) m_imem[load_addr] = load_word;
        @(posedge clk);
        @(negedge clk);
        m_slot = n_slot; m_acc = n_acc; m_pred = n_pred;
        chk({tg_s, " slot"}, 32'(slot_idx), 32'(m_slot));
        chk({tg, " result"}, result_out, m_acc);
        chk("R8 mac_valid", 32'(mac_req_valid), 32'(n_mv));
        if (n_mv) begin
            chk("R8 mac_a", mac_req_a, n_ma);
            chk("R8 mac_b", mac_req_b, n_mb);
        end
    endtask

    task automatic load(input int addr, input logic [8:0] word);
        load_en = 1'b1; load_addr = 5'(addr); load_word = word;
        tick();
        load_en = 1'b0;
    endtask

    task automatic set_nbr(input logic [31:0] n0, input logic [31:0] n1, input logic [31:0] n2, input logic [31:0] n3);
        nbr_data[0] = n0; nbr_data[1] = n1; nbr_data[2] = n2; nbr_data[3] = n3;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) m_imem[i] = '0;
        m_slot = '0; m_acc = '0; m_pred = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 slot", 32'(slot_idx), 0);
        chk("R1 result", result_out, 0);
        chk("R1 mac_valid", 32'(mac_req_valid), 0);
        // R1 unloaded store runs as no-operations
        force_tag = "R1";
        set_nbr(32'hAAAA_0001, 32'h5555_0002, 32'hFFFF_FFFF, 32'h0000_0100);
        step_en = 1'b1; sched_len = 6'd32;
        for (int i = 0; i < 34; i++) tick();
        force_tag = "";
        step_en = 1'b0;
        slot_restart = 1'b1; tick(); slot_restart = 1'b0;

        // Directed program over every opcode class
        load(0, enc(6, 1, 0, 0, 0));
        load(1, enc(1, 2, 1, 0, 0));
        load(2, enc(2, 0, 1, 0, 0));
        load(3, enc(7, 3, 1, 0, 0));
        load(4, enc(1, 0, 1, 1, 1));
        load(5, enc(5, 1, 1, 1, 0));
        load(6, enc(8, 2, 1, 0, 0));
        load(7, enc(15, 1, 1, 0, 0));
        load(8, enc(3, 3, 1, 0, 0));
        load(9, enc(4, 2, 1, 0, 0));
        sched_len = 6'd10;
        step_en = 1'b1;
        set_nbr(32'h0000_0010, 32'h0000_1000, 32'h0000_0300, 32'hFFFF_0000);
        for (int i = 0; i < 10; i++) tick();
        set_nbr(32'h0000_0001, 32'h8000_0000, 32'h0000_0007, 32'h0000_0002);
        for (int i = 0; i < 10; i++) tick();
        // R4 stall mid-schedule
        for (int i = 0; i < 3; i++) tick();
        step_en = 1'b0;
        for (int i = 0; i < 4; i++) tick();
        // R5 restart mid-schedule, then resume
        slot_restart = 1'b1; tick(); slot_restart = 1'b0;
        step_en = 1'b1; slot_restart = 1'b1; tick(); slot_restart = 1'b0;
        for (int i = 0; i < 5; i++) tick();

        // R3 schedule length sweep, including 0 and beyond the depth
        foreach (m_imem[i]) begin end
        for (int k = 0; k < 8; k++) begin
            int lens[8] = '{0, 1, 2, 7, 31, 32, 40, 63};
            sched_len = 6'(lens[k]);
            slot_restart = 1'b1; tick(); slot_restart = 1'b0;
            for (int i = 0; i < 70; i++) tick();
        end

        // R10 load into the slot about to execute and into later slots
        sched_len = 6'd4;
        slot_restart = 1'b1; tick(); slot_restart = 1'b0;
        set_nbr(32'd5, 32'd9, 32'd11, 32'd13);
        force_tag = "R10";
        for (int i = 0; i < 6; i++) begin
            load_en = 1'b1; load_addr = slot_idx; load_word = enc(1, i % 4, 1, 0, 0);
            tick();
            load_en = 1'b0;
            tick();
        end
        force_tag = "";

        // Pseudo-random programs, inputs and control
        for (int i = 0; i < 4000; i++) begin
            next_rand(); nbr_data[0] = rng;
            next_rand(); nbr_data[1] = rng;
            next_rand(); nbr_data[2] = (rng[3:0] == 0) ? 32'h0 : rng;
            next_rand(); nbr_data[3] = rng >> rng[4:0];
            next_rand();
            step_en      = (rng[2:0] != 3'd0);
            slot_restart = (rng[9:4] == 6'd0);
            load_en      = (rng[13:10] < 4'd3);
            load_addr    = rng[18:14];
            load_word    = rng[31:23];
            if (i % 500 == 0) sched_len = rng[21:16];
            tick();
        end
        load_en = 1'b0; step_en = 1'b0; slot_restart = 1'b0;
        tick();
        finish_run();
    end

endmodule